// File: doc/BRIEF.md
# Decade Counter with Selectable Wrap Method

This block is a synchronous counter that steps through the digits 0 to 9 and then starts again at 0. Underneath it is a plain 4-bit binary up-counter with a parallel load port and a count enable. A decoder watches the counter value and feeds back into that counter to cut the binary sequence short at ten states. A design-time parameter selects one of two feedback methods.

With the synchronous method, the decoder sees the value 9 while counting is enabled. It requests a load of zero, and the counter takes that load on the next rising clock edge. With the asynchronous method, the decoder sees the value 10 and drives the counter's clear input directly. The register drops to zero at once, so 10 appears only for a moment and is never present at a clock edge.

A caller can also load any 4-bit value. This external load wins over counting and over the feedback load. A terminal flag marks the cycle in which the next enabled edge will roll the count back to zero.

Top module: `decade_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is 0 after that edge.
- R2: When `cnt_en` is high, `ld_en` is low and `count` is neither 9 nor 15, the next edge makes `count` one greater.
- R3: When `ld_en` is high at an edge, `count` takes `ld_val` after that edge. This holds whatever `cnt_en` is and whatever the current value is, including 9. The one exception is that a loaded 10 in asynchronous mode reads back as 0 (see R6).
- R4: When `cnt_en` and `ld_en` are both low, `count` keeps its value across the edge, including the value 9.
- R5: Synchronous mode (`WRAP_MODE` = `WRAP_SYNC_LOAD`): an enabled edge at 9 with no external load gives 0. Values 10 to 15 occur only after an external load of such a value. From there the counter steps up to 15 and then to 0.
- R6: Asynchronous mode (`WRAP_MODE` = `WRAP_ASYNC_CLEAR`): `count` is never 10 when it is sampled between edges. A load of 10 reads back as 0. An enabled edge at 9 gives 0. Loaded values 11 to 15 step up to 15 and then to 0.
- R7: `term` is high exactly when `count` is 9 and `cnt_en` is high.
- R8: After reset with `cnt_en` held high and no loads, `count` follows 0,1,...,9,0,1,... exactly. In synchronous mode no value above 9 appears once the count has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0 |
| cnt_en | input | 1 | Count enable |
| ld_en | input | 1 | External parallel load request |
| ld_val | input | 4 | Value captured when `ld_en` is high |
| count | output | 4 | Current digit |
| term | output | 1 | High when `count` is 9 and counting is enabled |

## Verification
The assertions assume that `rst`, `cnt_en`, `ld_en` and `ld_val` change only away from the rising clock edge. They also assume that the clear pulse in asynchronous mode settles within the same time step, so the decoded 10 is never seen at an edge. The bench drives every input on the falling edge and compares on the next falling edge. That timing satisfies both assumptions. The stimulus covers free-running counts, pauses at 9, loads at 9, loads of every out-of-range value, and a reset in the middle of a count. Two instances, one per wrap mode, receive the same stimulus.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int DIGIT_W = 4;
    localparam int LAST_DIGIT = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        WRAP_SYNC_LOAD   = 1'b0,
        WRAP_ASYNC_CLEAR = 1'b1
    } wrap_mode_e;

    typedef struct packed {
        logic   valid;
        digit_t value;
    } load_req_t;

    localparam digit_t DIGIT_LAST = digit_t'(LAST_DIGIT);
    localparam digit_t DIGIT_OVER = digit_t'(LAST_DIGIT + 1);
    localparam digit_t DIGIT_MAX  = {DIGIT_W{1'b1}};

    function automatic logic is_value(input digit_t v, input digit_t ref_v);
        return v == ref_v;
    endfunction

endpackage

// File: rtl/dc_bin_core.sv
module dc_bin_core
    import decade_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      inc,
    input  load_req_t ld,
    output digit_t    q
);

    digit_t q_r;

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    q_r <= '0;
                end else if (rst) begin
                    q_r <= '0;
                end else if (ld.valid) begin
                    q_r <= ld.value;
                end else if (inc) begin
                    q_r <= q_r + digit_t'(1);
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    q_r <= '0;
                end else if (ld.valid) begin
                    q_r <= ld.value;
                end else if (inc) begin
                    q_r <= q_r + digit_t'(1);
                end
            end
        end
    endgenerate

    assign q = q_r;

    AST_CORE_RESET: assert property (@(posedge clk) rst |=> q_r == '0) // R1
        else $error("core not cleared by reset");
    AST_CORE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld.valid && !clr) |=> (q_r == $past(ld.value) || q_r == '0)) // R3
        else $error("core load not captured");

endmodule

// File: rtl/dc_wrap_ctrl.sv
module dc_wrap_ctrl
    import decade_pkg::*;
#(
    parameter wrap_mode_e WRAP_MODE = WRAP_SYNC_LOAD
) (
    input  digit_t    q,
    input  logic      cnt_en,
    input  load_req_t ext_ld,
    output load_req_t core_ld,
    output logic      inc,
    output logic      clr,
    output logic      at_last
);

    logic fb_ld;

    assign at_last = is_value(q, DIGIT_LAST);
    assign inc     = cnt_en;

    generate
        if (WRAP_MODE == WRAP_SYNC_LOAD) begin : g_sync_wrap
            assign fb_ld = at_last && cnt_en;
            assign clr   = 1'b0;
        end else begin : g_async_wrap
            assign fb_ld = 1'b0;
            assign clr   = is_value(q, DIGIT_OVER);
        end
    endgenerate

    always_comb begin
        core_ld.valid = ext_ld.valid || fb_ld;
        core_ld.value = ext_ld.valid ? ext_ld.value : '0;
    end

endmodule

// File: rtl/decade_counter.sv
module decade_counter
    import decade_pkg::*;
#(
    parameter wrap_mode_e WRAP_MODE = WRAP_SYNC_LOAD
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       ld_en,
    input  logic [3:0] ld_val,
    output logic [3:0] count,
    output logic       term
);

    localparam bit USE_ASYNC = (WRAP_MODE == WRAP_ASYNC_CLEAR);

    load_req_t ext_ld;
    load_req_t core_ld;
    digit_t    q;
    logic      inc;
    logic      clr;
    logic      at_last;

    assign ext_ld.valid = ld_en;
    assign ext_ld.value = ld_val;

    dc_wrap_ctrl #(
        .WRAP_MODE (WRAP_MODE)
    ) u_wrap (
        .q       (q),
        .cnt_en  (cnt_en),
        .ext_ld  (ext_ld),
        .core_ld (core_ld),
        .inc     (inc),
        .clr     (clr),
        .at_last (at_last)
    );

    dc_bin_core #(
        .ASYNC_CLR (USE_ASYNC)
    ) u_core (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .inc (inc),
        .ld  (core_ld),
        .q   (q)
    );

    assign count = q;
    assign term  = at_last && cnt_en;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> count == 4'd0) // R1
        else $error("reset did not zero count");
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !ld_en && count != 4'd9 && count != 4'd15) |=> count == $past(count) + 4'd1) // R2
        else $error("count did not step");
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !ld_en) |=> $stable(count)) // R4
        else $error("count changed while idle");
    AST_TERM_WRAP: assert property (@(posedge clk) disable iff (rst)
        (term && !ld_en) |=> count == 4'd0) // R7
        else $error("terminal cycle not followed by zero");
    AST_TOP_ROLL: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !ld_en && count == 4'd15) |=> count == 4'd0) // R5
        else $error("15 did not roll to 0");

    generate
        if (USE_ASYNC) begin : g_chk_async
            AST_NO_TEN: assert property (@(posedge clk) disable iff (rst)
                count != 4'd10) // R6
                else $error("10 visible at an edge");
            AST_LOAD_VAL: assert property (@(posedge clk) disable iff (rst)
                (ld_en && ld_val != 4'd10) |=> count == $past(ld_val)) // R3
                else $error("load not captured");
        end else begin : g_chk_sync
            AST_LOAD_VAL: assert property (@(posedge clk) disable iff (rst)
                ld_en |=> count == $past(ld_val)) // R3
                else $error("load not captured");
        end
    endgenerate

endmodule

// File: tb/decade_counter_tb.sv
module decade_counter_tb;
    import decade_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       ld_en = 1'b0;
    logic [3:0] ld_val = 4'd0;
    logic [3:0] cnt_s, cnt_a;
    logic       term_s, term_a;

    int tests = 0;
    int fails = 0;
    int m_s = 0;
    int m_a = 0;
    bit wrapped_s = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    decade_counter #(.WRAP_MODE(WRAP_SYNC_LOAD)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_en(ld_en),
        .ld_val(ld_val), .count(cnt_s), .term(term_s));

    decade_counter #(.WRAP_MODE(WRAP_ASYNC_CLEAR)) u_dut_async (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_en(ld_en),
        .ld_val(ld_val), .count(cnt_a), .term(term_a));

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        int ns, na;
        if (rst) begin
            ns = 0; na = 0;
        end else if (ld_en) begin
            ns = ld_val; na = ld_val;
        end else if (cnt_en) begin
            ns = (m_s == 9) ? 0 : (m_s + 1) % 16;
            na = (m_a + 1) % 16;
        end else begin
            ns = m_s; na = m_a;
        end
        if (na == 10) na = 0;
        if (!rst && !ld_en && cnt_en && m_s == 9) wrapped_s = 1'b1;
        if (rst || ld_en) wrapped_s = 1'b0;
        @(posedge clk);
        m_s = ns;
        m_a = na;
        @(negedge clk);
        check("R2/R3/R4/R5 sync count", int'(cnt_s), m_s);
        check("R2/R3/R4/R6 async count", int'(cnt_a), m_a);
        check("R7 sync term", int'(term_s), int'(m_s == 9 && cnt_en));
        check("R7 async term", int'(term_a), int'(m_a == 9 && cnt_en));
        check("R6 no ten in async", int'(cnt_a == 4'd10), 0);
        if (wrapped_s) check("R8 sync stays in range", int'(cnt_s > 4'd9), 0);
    endtask

    task automatic load(input int v);
        ld_en = 1'b1; ld_val = 4'(v);
        step();
        ld_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        step();
        check("R1 reset sync", int'(cnt_s), 0);
        check("R1 reset async", int'(cnt_a), 0);
        rst = 1'b0;
        cnt_en = 1'b1;
        for (int k = 1; k <= 25; k++) begin
            step();
            check("R8 decade sequence sync", int'(cnt_s), k % 10);
            check("R8 decade sequence async", int'(cnt_a), k % 10);
        end
        while (cnt_s != 4'd9) step();
        cnt_en = 1'b0;
        for (int k = 0; k < 3; k++) step();
        check("R4 hold at 9", int'(cnt_s), 9);
        cnt_en = 1'b1;
        step();
        check("R5 sync 9 to 0", int'(cnt_s), 0);
        check("R6 async 9 to 0", int'(cnt_a), 0);
        load(9);
        load(3);
        check("R3 load over wrap at 9", int'(cnt_s), 3);
        cnt_en = 1'b0;
        load(7);
        check("R3 load with enable low", int'(cnt_a), 7);
        cnt_en = 1'b1;
        load(12);
        check("R5 sync load 12", int'(cnt_s), 12);
        for (int k = 0; k < 5; k++) step();
        check("R5 sync 12 rolls through 15 to 1", int'(cnt_s), 1);
        load(10);
        check("R5 sync load 10", int'(cnt_s), 10);
        check("R6 async load 10 reads 0", int'(cnt_a), 0);
        step();
        check("R6 async 0 to 1", int'(cnt_a), 1);
        load(15);
        step();
        check("R5 15 rolls to 0", int'(cnt_s), 0);
        for (int v = 11; v < 16; v++) begin
            load(v);
            for (int k = 0; k < 6; k++) step();
        end
        for (int k = 0; k < 4; k++) step();
        rst = 1'b1;
        step();
        check("R1 mid-count reset", int'(cnt_s), 0);
        rst = 1'b0;
        for (int k = 0; k < 40; k++) begin
            cnt_en = (k % 7) != 3;
            step();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule